// File: doc/BRIEF.md
# Memory region access control filter

This block sits between the load/store port of a 32-bit core and a 32-bit downstream memory bus, and applies per-region access rules to every transfer. The upper four address bits pick one of sixteen fixed 256 MB regions. Each region has two attribute bits in a 32-bit control register. The core writes and reads that register through a CSR-style port at CSR address 0x7C0.

A region marked side-effect forwards only aligned word transfers. Any other size or alignment is answered with a misalignment fault, and nothing is issued downstream. In a region marked cacheable, a read becomes a fetch of the enclosing 8-byte block, issued as two word reads. The requested bytes are then taken from that block. A region with no attribute passes transfers through untouched. The global enable input, sampled when a request is accepted, turns all checks off.

The core handshake is single-phase: a request is taken on a cycle where `req_valid` and `req_ready` are both high. The bus beat completes on a cycle where `bus_valid` and `bus_ready` are both high, and `bus_rdata` is valid in that same cycle.

Top module: `region_access_filter`

## Requirements
- R1: After reset the control register reads zero, `req_ready` is high, and `bus_valid` and `rsp_valid` are low. With the register at zero, every transfer passes through unchanged.
- R2: A CSR write to address 0x7C0 stores each 2-bit region field unchanged, except a field written as 11, which is stored as 10. The register reads back at 0x7C0. A write to any other CSR address leaves it unchanged, and a read of any other address returns zero.
- R3: Address bits [31:28] give the region index Y. Register bit 2Y is the cacheable flag and bit 2Y+1 is the side-effect flag.
- R4: In a side-effect region, a word transfer (size code 10) at a word-aligned address goes downstream once, with its address, size, write flag, data and strobes unchanged. A read returns `bus_rdata` unchanged, and a write returns zero data.
- R5: In a side-effect region, a read with a size code other than 10 (byte 00, halfword 01, reserved 11), or with address bits [1:0] not zero, produces no bus transfer. It gets a single-cycle response with `rsp_fault` = 01.
- R6: The same rule for a write gives `rsp_fault` = 10, with no bus transfer.
- R7: In a cacheable region with the side-effect flag clear, a read issues two word reads: first at the address with bits [2:0] cleared, then at that address plus 4. The response comes only after both have completed. Its data is the 8-byte block (first word in the low half) shifted right by 8 x address[2:0] bits and masked to the request size (byte 0xFF, halfword 0xFFFF). Bytes beyond the block read as zero.
- R8: A write to a cacheable region goes downstream once, with its original address, size and strobes.
- R9: When `filt_en` is low at acceptance, or the region has both flags clear, a transfer of any size or alignment passes through unchanged as a single bus transfer.
- R10: `req_ready` is high only while no transfer is in progress. `rsp_valid` lasts exactly one cycle per request. While `bus_ready` is low, the bus outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| filt_en | input | 1 | Global enable for region checks, sampled at request acceptance |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data (combinational) |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Filter can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Core byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word |
| req_wdata | input | 32 | Store data |
| req_strb | input | 4 | Store byte strobes |
| rsp_valid | output | 1 | Single-cycle response |
| rsp_rdata | output | 32 | Load data |
| rsp_fault | output | 2 | 00 none, 01 load misaligned, 10 store misaligned |
| bus_valid | output | 1 | Downstream transfer valid |
| bus_ready | input | 1 | Downstream accepts and completes the beat |
| bus_write | output | 1 | Downstream write flag |
| bus_addr | output | 32 | Downstream address |
| bus_size | output | 2 | Downstream size code |
| bus_wdata | output | 32 | Downstream write data |
| bus_strb | output | 4 | Downstream byte strobes |
| bus_rdata | input | 32 | Downstream read data, valid with the handshake |

## Verification
Some rules are checked by assertions on every cycle:
- the stored register never holds an 11 field, and does not change without a write that hits its address;
- a transfer from a side-effect region is always an aligned word;
- the second half of a widened read follows the first at the next word address;
- fault responses follow acceptance directly;
- responses last one cycle, and bus outputs hold during a stall.

Other behaviour only the bench scenarios can show: the fault codes chosen, the byte selection out of the assembled block, unchanged pass-through fields, and the effect of the enable and of legalization on later transfers.

// File: rtl/rac_pkg.sv
package rac_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    FLT_NONE      = 2'b00,
    FLT_LOAD_MIS  = 2'b01,
    FLT_STORE_MIS = 2'b10
  } fault_e;

  typedef enum logic [1:0] {
    ROUTE_PASS  = 2'd0,
    ROUTE_WIDEN = 2'd1,
    ROUTE_FAULT = 2'd2
  } route_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PASS  = 3'd1,
    ST_LO    = 3'd2,
    ST_HI    = 3'd3,
    ST_RESP  = 3'd4,
    ST_FAULT = 3'd5
  } seq_state_e;

endpackage

// File: rtl/rac_ctrl_reg.sv
module rac_ctrl_reg
  import rac_pkg::*;
#(
  parameter int          NUM_REGIONS = 16,
  parameter int          CSR_ADDR_W  = 12,
  parameter int unsigned CSR_SEL     = 'h7C0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     csr_we,
  input  logic [CSR_ADDR_W-1:0]    csr_addr,
  input  logic [2*NUM_REGIONS-1:0] csr_wdata,
  output logic [2*NUM_REGIONS-1:0] csr_rdata,
  output logic [2*NUM_REGIONS-1:0] attr_o
);

  localparam int REG_W = 2 * NUM_REGIONS;

  logic             sel_hit;
  logic             wr_en;
  logic [REG_W-1:0] legal_w;
  logic [REG_W-1:0] ctrl_d;
  logic [REG_W-1:0] ctrl_q;

  assign sel_hit = (csr_addr == CSR_ADDR_W'(CSR_SEL));
  assign wr_en   = csr_we && sel_hit;

  // Per-field legalization: the pair "cacheable + side-effect" is folded
  // into side-effect only.
  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_legal
    assign legal_w[2*g +: 2] = (&csr_wdata[2*g +: 2]) ? 2'b10 : csr_wdata[2*g +: 2];
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d = legal_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign csr_rdata = sel_hit ? ctrl_q : '0;
  assign attr_o    = ctrl_q;

  logic pair_seen;
  always_comb begin
    pair_seen = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      pair_seen = pair_seen | (ctrl_q[2*i] & ctrl_q[2*i+1]);
    end
  end

  assert_no_illegal_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_seen);

  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_we && sel_hit) |=> $stable(ctrl_q));

endmodule

// File: rtl/rac_classify.sv
module rac_classify
  import rac_pkg::*;
#(
  parameter int NUM_REGIONS = 16,
  parameter int IDX_W       = $clog2(NUM_REGIONS)
) (
  input  logic                     en_i,
  input  logic [2*NUM_REGIONS-1:0] attr_i,
  input  logic [IDX_W-1:0]         region_i,
  input  logic [1:0]               addr_lo_i,
  input  logic [1:0]               size_i,
  input  logic                     write_i,
  output route_e                   route_o,
  output fault_e                   fault_o,
  output logic                     se_hit_o
);

  logic [NUM_REGIONS-1:0] se_vec;
  logic [NUM_REGIONS-1:0] ca_vec;

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_flags
    assign se_vec[g] = attr_i[2*g+1];
    assign ca_vec[g] = attr_i[2*g] & ~attr_i[2*g+1];
  end

  logic sel_se;
  logic sel_ca;
  logic word_ok;

  assign sel_se  = en_i && se_vec[region_i];
  assign sel_ca  = en_i && ca_vec[region_i];
  assign word_ok = (size_i == SZ_WORD) && (addr_lo_i == 2'b00);

  always_comb begin
    route_o = ROUTE_PASS;
    fault_o = FLT_NONE;
    if (sel_se) begin
      if (!word_ok) begin
        route_o = ROUTE_FAULT;
        fault_o = write_i ? FLT_STORE_MIS : FLT_LOAD_MIS;
      end
    end else if (sel_ca && !write_i) begin
      route_o = ROUTE_WIDEN;
    end
  end

  assign se_hit_o = sel_se;

endmodule

// File: rtl/rac_seq.sv
module rac_seq
  import rac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W/8-1:0] req_strb,
  input  route_e            route_i,
  input  fault_e            fault_i,
  input  logic              se_hit_i,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [1:0]        rsp_fault,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W/8-1:0] bus_strb,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int STRB_W  = DATA_W / 8;
  localparam int BLK_B   = 2 * STRB_W;
  localparam int BLK_LSB = $clog2(BLK_B);
  localparam int SH_W    = BLK_LSB + 3;

  seq_state_e state_q, state_d;

  logic [ADDR_W-1:0] cap_addr_q;
  logic              cap_write_q;
  logic [1:0]        cap_size_q;
  logic [DATA_W-1:0] cap_wdata_q;
  logic [STRB_W-1:0] cap_strb_q;
  fault_e            cap_fault_q;
  logic              cap_se_q;

  logic [DATA_W-1:0] lo_q, lo_d;
  logic [DATA_W-1:0] data_q, data_d;

  logic accept;
  logic beat;
  logic lo_en;
  logic data_en;

  assign accept  = (state_q == ST_IDLE) && req_valid;
  assign beat    = bus_valid && bus_ready;
  assign lo_en   = (state_q == ST_LO) && bus_ready;
  assign data_en = ((state_q == ST_PASS) || (state_q == ST_HI)) && bus_ready;

  // Next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          case (route_i)
            ROUTE_FAULT: state_d = ST_FAULT;
            ROUTE_WIDEN: state_d = ST_LO;
            default:     state_d = ST_PASS;
          endcase
        end
      end
      ST_PASS:  if (bus_ready) state_d = ST_RESP;
      ST_LO:    if (bus_ready) state_d = ST_HI;
      ST_HI:    if (bus_ready) state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Block assembly and byte selection for widened reads
  logic [2*DATA_W-1:0] blk;
  logic [SH_W-1:0]     shamt;
  logic [DATA_W-1:0]   picked;
  logic [DATA_W-1:0]   shaped;

  assign blk    = {bus_rdata, lo_q};
  assign shamt  = {cap_addr_q[BLK_LSB-1:0], 3'b000};
  assign picked = DATA_W'(blk >> shamt);

  always_comb begin
    case (cap_size_q)
      SZ_BYTE: shaped = picked & DATA_W'({8{1'b1}});
      SZ_HALF: shaped = picked & DATA_W'({16{1'b1}});
      default: shaped = picked;
    endcase
  end

  always_comb begin
    lo_d   = lo_en ? bus_rdata : lo_q;
    data_d = data_q;
    if (data_en) begin
      if (state_q == ST_HI) begin
        data_d = shaped;
      end else begin
        data_d = cap_write_q ? '0 : bus_rdata;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q  <= '0;
      cap_write_q <= 1'b0;
      cap_size_q  <= 2'b00;
      cap_wdata_q <= '0;
      cap_strb_q  <= '0;
      cap_fault_q <= FLT_NONE;
      cap_se_q    <= 1'b0;
    end else if (accept) begin
      cap_addr_q  <= req_addr;
      cap_write_q <= req_write;
      cap_size_q  <= req_size;
      cap_wdata_q <= req_wdata;
      cap_strb_q  <= req_strb;
      cap_fault_q <= fault_i;
      cap_se_q    <= se_hit_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  // Outputs
  logic [ADDR_W-1:0] blk_base;
  assign blk_base = {cap_addr_q[ADDR_W-1:BLK_LSB], {BLK_LSB{1'b0}}};

  always_comb begin
    bus_valid = 1'b0;
    bus_write = 1'b0;
    bus_addr  = cap_addr_q;
    bus_size  = cap_size_q;
    bus_wdata = cap_wdata_q;
    bus_strb  = cap_strb_q;
    case (state_q)
      ST_PASS: begin
        bus_valid = 1'b1;
        bus_write = cap_write_q;
      end
      ST_LO: begin
        bus_valid = 1'b1;
        bus_addr  = blk_base;
        bus_size  = SZ_WORD;
        bus_strb  = '1;
      end
      ST_HI: begin
        bus_valid = 1'b1;
        bus_addr  = blk_base | ADDR_W'(STRB_W);
        bus_size  = SZ_WORD;
        bus_strb  = '1;
      end
      default: ;
    endcase
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP) || (state_q == ST_FAULT);
  assign rsp_rdata = (state_q == ST_RESP) ? data_q : '0;
  assign rsp_fault = (state_q == ST_FAULT) ? cap_fault_q : FLT_NONE;

  // Checks
  assert_se_word_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && cap_se_q) |-> (bus_size == SZ_WORD && bus_addr[1:0] == 2'b00));

  assert_fault_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> $past(req_valid && req_ready && !bus_valid));

  assert_widen_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && state_q == ST_LO) |=> (bus_valid && bus_addr == $past(bus_addr) + ADDR_W'(STRB_W)));

  assert_rsp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_write)
                                   && $stable(bus_size)));

  assert_ready_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!bus_valid && !rsp_valid));

endmodule

// File: rtl/region_access_filter.sv
module region_access_filter
  import rac_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 32,
  parameter int          NUM_REGIONS = 16,
  parameter int          CSR_ADDR_W  = 12,
  parameter int unsigned CSR_SEL     = 'h7C0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     filt_en,
  input  logic                     csr_we,
  input  logic [CSR_ADDR_W-1:0]    csr_addr,
  input  logic [2*NUM_REGIONS-1:0] csr_wdata,
  output logic [2*NUM_REGIONS-1:0] csr_rdata,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               req_size,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W/8-1:0]      req_strb,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [1:0]               rsp_fault,
  output logic                     bus_valid,
  input  logic                     bus_ready,
  output logic                     bus_write,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [1:0]               bus_size,
  output logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W/8-1:0]      bus_strb,
  input  logic [DATA_W-1:0]        bus_rdata
);

  localparam int IDX_W = $clog2(NUM_REGIONS);

  logic [2*NUM_REGIONS-1:0] attr;
  route_e                   route;
  fault_e                   fault;
  logic                     se_hit;

  rac_ctrl_reg #(
    .NUM_REGIONS (NUM_REGIONS),
    .CSR_ADDR_W  (CSR_ADDR_W),
    .CSR_SEL     (CSR_SEL)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .attr_o    (attr)
  );

  rac_classify #(
    .NUM_REGIONS (NUM_REGIONS),
    .IDX_W       (IDX_W)
  ) u_class (
    .en_i      (filt_en),
    .attr_i    (attr),
    .region_i  (req_addr[ADDR_W-1 -: IDX_W]),
    .addr_lo_i (req_addr[1:0]),
    .size_i    (req_size),
    .write_i   (req_write),
    .route_o   (route),
    .fault_o   (fault),
    .se_hit_o  (se_hit)
  );

  rac_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .req_strb  (req_strb),
    .route_i   (route),
    .fault_i   (fault),
    .se_hit_i  (se_hit),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_fault (rsp_fault),
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_strb  (bus_strb),
    .bus_rdata (bus_rdata)
  );

endmodule

// File: tb/region_access_filter_test.sv
module region_access_filter_test;

  logic        clk;
  logic        rst_n;
  logic        filt_en;
  logic        csr_we;
  logic [11:0] csr_addr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [31:0] req_wdata;
  logic [3:0]  req_strb;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  rsp_fault;
  logic        bus_valid;
  logic        bus_ready;
  logic        bus_write;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_strb;
  logic [31:0] bus_rdata;

  region_access_filter uut (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[15:0]};
  endfunction

  assign bus_rdata = mem_word({bus_addr[31:2], 2'b00});

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Bus monitor
  int          nbus;
  logic [31:0] baddr [2];
  logic [1:0]  bsize0;
  logic        bwr0;
  logic [3:0]  bstrb0;
  logic [31:0] bwdata0;

  always @(negedge clk) begin
    if (bus_valid && bus_ready) begin
      if (nbus < 2) baddr[nbus] = bus_addr;
      if (nbus == 0) begin
        bsize0  = bus_size;
        bwr0    = bus_write;
        bstrb0  = bus_strb;
        bwdata0 = bus_wdata;
      end
      nbus = nbus + 1;
    end
  end

  logic [31:0] got_data;
  logic [1:0]  got_fault;

  task automatic access(input logic en, input logic wr, input logic [31:0] a,
                        input logic [1:0] sz, input logic [3:0] st, input logic [31:0] wd);
    nbus = 0;
    @(posedge clk); #1;
    filt_en = en; req_write = wr; req_addr = a; req_size = sz;
    req_strb = st; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (rsp_valid) break;
    end
    got_data  = rsp_rdata;
    got_fault = rsp_fault;
    @(negedge clk);
    check(!rsp_valid, "R10 response longer than one cycle", 32'(rsp_valid), 32'd0);
  endtask

  task automatic csr_write(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(posedge clk); #1;
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [11:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    csr_addr = a;
    @(negedge clk);
    d = csr_rdata;
  endtask

  typedef struct packed {
    logic        en;
    logic        wr;
    logic [31:0] addr;
    logic [1:0]  size;
    logic [3:0]  strb;
    logic [1:0]  exp_fault;
    logic [1:0]  exp_nbus;
    logic [31:0] exp_addr0;
    logic [1:0]  exp_size0;
    logic [31:0] exp_rdata;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VT [NV] = '{
    '{1'b1, 1'b0, 32'h0000_0101, 2'b00, 4'h0, 2'b00, 2'd1, 32'h0000_0101, 2'b00, 32'h5B5A_0100, 4'd9}, // R9
    '{1'b1, 1'b0, 32'h1000_0006, 2'b01, 4'h0, 2'b00, 2'd2, 32'h1000_0000, 2'b10, 32'h0000_5A5E, 4'd7}, // R7
    '{1'b1, 1'b0, 32'h1000_0004, 2'b10, 4'h0, 2'b00, 2'd2, 32'h1000_0000, 2'b10, 32'h5A5E_0004, 4'd7}, // R7
    '{1'b1, 1'b0, 32'h1000_0003, 2'b00, 4'h0, 2'b00, 2'd2, 32'h1000_0000, 2'b10, 32'h0000_005A, 4'd7}, // R7
    '{1'b1, 1'b0, 32'h1000_0006, 2'b10, 4'h0, 2'b00, 2'd2, 32'h1000_0000, 2'b10, 32'h0000_5A5E, 4'd7}, // R7
    '{1'b1, 1'b0, 32'hF000_0010, 2'b10, 4'h0, 2'b00, 2'd2, 32'hF000_0010, 2'b10, 32'h5A4A_0010, 4'd3}, // R3
    '{1'b1, 1'b0, 32'h2000_0008, 2'b10, 4'h0, 2'b00, 2'd1, 32'h2000_0008, 2'b10, 32'h5A52_0008, 4'd4}, // R4
    '{1'b1, 1'b0, 32'h2000_0008, 2'b00, 4'h0, 2'b01, 2'd0, 32'h0,         2'b00, 32'h0,         4'd5}, // R5
    '{1'b1, 1'b0, 32'h2000_0000, 2'b01, 4'h0, 2'b01, 2'd0, 32'h0,         2'b00, 32'h0,         4'd5}, // R5
    '{1'b1, 1'b0, 32'h2000_0002, 2'b10, 4'h0, 2'b01, 2'd0, 32'h0,         2'b00, 32'h0,         4'd5}, // R5
    '{1'b1, 1'b1, 32'h2000_0001, 2'b10, 4'hF, 2'b10, 2'd0, 32'h0,         2'b00, 32'h0,         4'd6}, // R6
    '{1'b1, 1'b1, 32'h2000_0004, 2'b01, 4'h3, 2'b10, 2'd0, 32'h0,         2'b00, 32'h0,         4'd6}, // R6
    '{1'b1, 1'b1, 32'h2000_000C, 2'b10, 4'hF, 2'b00, 2'd1, 32'h2000_000C, 2'b10, 32'h0,         4'd4}, // R4
    '{1'b1, 1'b0, 32'h3000_0000, 2'b00, 4'h0, 2'b01, 2'd0, 32'h0,         2'b00, 32'h0,         4'd2}, // R2
    '{1'b1, 1'b1, 32'hE000_0007, 2'b00, 4'h8, 2'b10, 2'd0, 32'h0,         2'b00, 32'h0,         4'd3}, // R3
    '{1'b1, 1'b1, 32'h1000_0005, 2'b00, 4'h2, 2'b00, 2'd1, 32'h1000_0005, 2'b00, 32'h0,         4'd8}, // R8
    '{1'b0, 1'b0, 32'h2000_0003, 2'b00, 4'h0, 2'b00, 2'd1, 32'h2000_0003, 2'b00, 32'h5A5A_0000, 4'd9}, // R9
    '{1'b0, 1'b0, 32'h1000_0004, 2'b10, 4'h0, 2'b00, 2'd1, 32'h1000_0004, 2'b10, 32'h5A5E_0004, 4'd9}, // R9
    '{1'b1, 1'b0, 32'h2000_0000, 2'b11, 4'h0, 2'b01, 2'd0, 32'h0,         2'b00, 32'h0,         4'd5}  // R5
  };

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; filt_en = 1'b1; csr_we = 1'b0; csr_addr = 12'h7C0; csr_wdata = '0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_size = 2'b00;
    req_wdata = '0; req_strb = '0; bus_ready = 1'b1; nbus = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check(csr_rdata == 32'h0, "R1 register after reset", csr_rdata, 32'h0);
    check(req_ready && !bus_valid && !rsp_valid, "R1 idle outputs after reset",
          {29'b0, req_ready, bus_valid, rsp_valid}, 32'h4);
    access(1'b1, 1'b0, 32'h2000_0001, 2'b00, 4'h0, 32'h0);
    check(got_fault == 2'b00 && nbus == 1, "R1 pass-through with zero register",
          32'(nbus), 32'd1);

    // R2: legalization and address decode
    csr_write(12'h7C0, 32'h7000_00E4);
    csr_read(12'h7C0, rd);
    check(rd == 32'h6000_00A4, "R2 legalized readback", rd, 32'h6000_00A4);
    csr_write(12'h7C1, 32'hFFFF_FFFF);
    csr_read(12'h7C1, rd);
    check(rd == 32'h0, "R2 other address reads zero", rd, 32'h0);
    csr_read(12'h7C0, rd);
    check(rd == 32'h6000_00A4, "R2 other address write ignored", rd, 32'h6000_00A4);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d vec%0d", VT[i].rq, i);
      access(VT[i].en, VT[i].wr, VT[i].addr, VT[i].size, VT[i].strb, 32'hCAFE_0000 + 32'(i));
      check(got_fault == VT[i].exp_fault, {tg, " fault"}, 32'(got_fault), 32'(VT[i].exp_fault));
      check(nbus == int'(VT[i].exp_nbus), {tg, " bus count"}, 32'(nbus), 32'(VT[i].exp_nbus));
      if (VT[i].exp_nbus != 0) begin
        check(baddr[0] == VT[i].exp_addr0, {tg, " bus addr"}, baddr[0], VT[i].exp_addr0);
        check(bsize0 == VT[i].exp_size0, {tg, " bus size"}, 32'(bsize0), 32'(VT[i].exp_size0));
        check(bwr0 == VT[i].wr, {tg, " bus write"}, 32'(bwr0), 32'(VT[i].wr));
        check(got_data == VT[i].exp_rdata, {tg, " data"}, got_data, VT[i].exp_rdata);
        if (VT[i].wr) begin
          check(bstrb0 == VT[i].strb, {tg, " strobes"}, 32'(bstrb0), 32'(VT[i].strb));
          check(bwdata0 == 32'hCAFE_0000 + 32'(i), {tg, " wdata"}, bwdata0,
                32'hCAFE_0000 + 32'(i));
        end
      end
      if (VT[i].exp_nbus == 2) begin
        check(baddr[1] == VT[i].exp_addr0 + 32'd4, {tg, " second addr"}, baddr[1],
              VT[i].exp_addr0 + 32'd4);
      end
    end

    // R7/R10: widened read with a stalled bus
    nbus = 0;
    @(posedge clk); #1;
    filt_en = 1'b1; req_write = 1'b0; req_addr = 32'h1000_0002; req_size = 2'b01;
    req_valid = 1'b1; bus_ready = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    rd = bus_addr;
    @(negedge clk);
    check(bus_valid && bus_addr == rd && rd == 32'h1000_0000, "R10 bus holds while stalled",
          bus_addr, 32'h1000_0000);
    check(!rsp_valid, "R7 no response before both reads", 32'(rsp_valid), 32'd0);
    @(posedge clk); #1;
    bus_ready = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (rsp_valid) break;
    end
    check(rsp_rdata == 32'h0000_5A5A && nbus == 2, "R7 stalled widened read data",
          rsp_rdata, 32'h0000_5A5A);

    // R1: reset clears the register
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    csr_read(12'h7C0, rd);
    check(rd == 32'h0, "R1 register cleared by reset", rd, 32'h0);

    finish_up();
  end

endmodule